// File: doc/BRIEF.md
# Local Interrupt Timer with Prescaler

This block is the one-shot countdown timer of a local interrupt controller. Software programs it through a small register window. A 3-bit divide code picks a power-of-two prescale ratio from 1 to 128 input clocks per timer tick. Writing a nonzero initial count arms the timer. The count then drops by one on every prescaled tick. When it reaches zero, the block raises a single-cycle expiry pulse toward the interrupt logic and stops. Software can read the remaining count back at any time.

Register traffic uses a request channel and a response channel, each with valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. A write transfers with no response beat. A read returns exactly one response beat, which transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While a response is held because `rsp_ready` is low, `req_ready` stays low, so the requester is back-pressured and at most one read is outstanding. `req_ready` goes high again in the cycle in which the held response is taken. The expiry pulse is a plain control output and has no handshake.

Top module: `lt_timer`

## Requirements
- R1: After reset, the divide field reads 0, the initial count reads 0, the current count reads 0, `expire` is low, `rsp_valid` is low and `req_ready` is high.
- R2: The divide register is at offset 0x3E0. Its data bits 3, 1 and 0 form a 3-bit code, with bit 3 as the MSB. The prescale ratio is 2^((code+1) mod 8), so code 0 gives /2, code 3 gives /16, code 6 gives /128 and code 7 gives /1.
- R3: A write to the divide register stores only the bits under mask 0xB. The other bits read back as 0.
- R4: A write of a nonzero value N to the initial-count register (offset 0x380) starts a countdown. `expire` is high in exactly the cycle that follows the N×ratio-th rising edge after the accepting edge.
- R5: The expiry pulse lasts one cycle. After it the timer is idle and the current count reads 0.
- R6: A read of the current-count register (offset 0x390) returns the remaining ticks, rounded up. For a read accepted d+1 edges after arming (d ≥ 0), the value is N − floor(d/ratio), or 0 once d ≥ N×ratio. It also reads 0 while the timer is idle.
- R7: Writes to the current-count register have no effect on the count or on the expiry time.
- R8: Writing 0 to the initial-count register stops a running timer without any expiry pulse, and the current count then reads 0.
- R9: The timer local-vector register (offset 0x320) stores written data, except bits 12 and 14. These are read-only and read as 0.
- R10: While a read response is held with `rsp_ready` low, `req_ready` is low, and `rsp_valid` and `rsp_data` stay stable.
- R11: Writing a new nonzero initial count while the timer runs restarts the countdown from the new value. The expiry time is measured from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; prescaler and counter advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request is present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response is present |
| rsp_ready | input | 1 | Requester takes the read response |
| rsp_data | output | 32 | Read data |
| expire | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
The assertions assume that `rsp_ready` and the request fields are driven to known levels once reset is released, and that software does not change the divide code during a running countdown except as a deliberate restart. The prescaler range check is relaxed for one cycle after a ratio change for exactly that reason. The stimulus programs the divide code only while the timer is idle or just before arming. It drives requests only at falling edges, after seeing `req_ready` high. It lowers `rsp_ready` only around one isolated read, so every expected response and expiry cycle can be predicted from the accepting edge alone.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int AW = 12;
  localparam int DIV_CODE_W = 3;

  localparam logic [AW-1:0] OFS_LVT  = 12'h320;
  localparam logic [AW-1:0] OFS_INIT = 12'h380;
  localparam logic [AW-1:0] OFS_CUR  = 12'h390;
  localparam logic [AW-1:0] OFS_DIV  = 12'h3E0;

  localparam logic [31:0] LVT_RO_MASK = 32'h0000_5000;

  typedef struct packed {
    logic lvt;
    logic init;
    logic cur;
    logic div;
  } reg_sel_t;
endpackage

// File: rtl/lt_div_decode.sv
module lt_div_decode #(
  parameter int SHW   = 3,
  localparam int PRE_W = (1 << SHW) - 1
) (
  input  logic [SHW-1:0]   code,
  output logic [PRE_W-1:0] ratio_m1
);
  logic [SHW-1:0] shift;

  // rotated encoding: code + 1 wraps, so the all-ones code selects /1
  assign shift    = code + SHW'(1);
  assign ratio_m1 = ~({PRE_W{1'b1}} << shift);
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q >= ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

  p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ratio_m1) |-> (pre_q <= ratio_m1));

  p_ratio_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ratio_m1 + PRE_W'(1)) & ratio_m1) == '0);
endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             running;

  assign running = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      exp_q <= 1'b0;
    end else if (running && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      exp_q <= (cnt_q == CNT_W'(1));
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign count  = cnt_q;
  assign expire = exp_q;

  p_last_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(cnt_q) == CNT_W'(1)));

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!expire || $past(load)));

  p_no_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> !expire);
endmodule

// File: rtl/lt_regif.sv
module lt_regif
  import lt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DW-1:0]         rsp_data,
  input  logic [DW-1:0]         cur_count,
  output logic [DIV_CODE_W-1:0] div_code,
  output logic                  load,
  output logic [DW-1:0]         load_val
);
  localparam logic [DW-1:0] RO_MASK = DW'(LVT_RO_MASK);

  reg_sel_t              sel;
  logic                  acc, acc_wr, acc_rd;
  logic [DW-1:0]         lvt_q, init_q, rd_mux;
  logic [DIV_CODE_W-1:0] div_q;
  logic                  rsp_valid_q;
  logic [DW-1:0]         rsp_data_q;

  always_comb begin
    sel      = '0;
    sel.lvt  = (req_addr == OFS_LVT);
    sel.init = (req_addr == OFS_INIT);
    sel.cur  = (req_addr == OFS_CUR);
    sel.div  = (req_addr == OFS_DIV);
  end

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;
  assign acc_rd    = acc && !req_write;

  assign load     = acc_wr && sel.init;
  assign load_val = req_wdata;

  always_comb begin
    rd_mux = '0;
    if (sel.lvt)  rd_mux = lvt_q;
    if (sel.init) rd_mux = init_q;
    if (sel.cur)  rd_mux = cur_count;
    if (sel.div)  rd_mux = DW'({div_q[2], 1'b0, div_q[1:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvt_q       <= '0;
      init_q      <= '0;
      div_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (acc_wr && sel.lvt)
        lvt_q <= (req_wdata & ~RO_MASK) | (lvt_q & RO_MASK);
      if (acc_wr && sel.init)
        init_q <= req_wdata;
      if (acc_wr && sel.div)
        div_q <= {req_wdata[3], req_wdata[1:0]};
      if (acc_rd) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign div_code  = div_q;

  p_hold_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_read_answers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_lvt_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvt_q & RO_MASK) == '0);
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = DIV_CODE_W,
  localparam int PRE_W = (1 << SHW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          expire
);
  logic [DIV_CODE_W-1:0] div_code;
  logic [PRE_W-1:0]      ratio_m1;
  logic                  load, tick;
  logic [DW-1:0]         load_val, count;

  lt_regif #(.DW(DW)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .cur_count (count),
    .div_code  (div_code),
    .load      (load),
    .load_val  (load_val)
  );

  lt_div_decode #(.SHW(SHW)) u_dec (
    .code     (div_code),
    .ratio_m1 (ratio_m1)
  );

  lt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .ratio_m1 (ratio_m1),
    .tick     (tick)
  );

  lt_downcount #(.CNT_W(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .count    (count),
    .expire   (expire)
  );
endmodule

// File: tb/sim_lt_timer.sv
`timescale 1ns/1ps
module sim_lt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, expire;
  logic [31:0] rsp_data;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  bit     done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  bit     arm_on = 0;
  longint arm_a = 0, arm_n = 0, arm_r = 2, cur_r = 2;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lt_timer u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .expire(expire)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive one request; returns the cycle stamp of the accepting edge
  task automatic issue(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       output longint acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    longint acc;
    issue(1'b1, a, d, acc);
    if (a == 12'h3E0) cur_r = 64'd1 << ((({d[3], d[1:0]}) + 1) % 8);
    if (a == 12'h380) begin
      arm_on = (d != 0); arm_a = acc; arm_n = d; arm_r = cur_r;
    end
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [31:0] e, input string req);
    longint acc;
    exp_q.push_back(e); tag_q.push_back(req);
    issue(1'b0, a, 32'h0, acc);
  endtask

  function automatic logic [31:0] cur_model(input longint b);
    longint d;
    if (!arm_on) return 32'h0;
    d = b - 1 - arm_a;
    if (d >= arm_n * arm_r) return 32'h0;
    return 32'(arm_n - d / arm_r);
  endfunction

  // read of the current count; expected value fixed by the accepting edge
  task automatic rd_cur(input string req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h390;
    @(posedge clk);
    #1;
    exp_q.push_back(cur_model(cyc)); tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: response beats and the expiry pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ex;
      ex = arm_on && (cyc == arm_a + arm_n * arm_r);
      chk(expire == ex, "R4/R5 expire", expire, ex);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", rsp_data, 0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(rsp_data == e, t, rsp_data, e);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog (all R) actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(expire == 1'b0, "R1 expire", expire, 0);
    rd_reg(12'h3E0, 32'h0, "R1 divide");
    rd_reg(12'h380, 32'h0, "R1 initial");
    rd_cur("R1 current");

    // R3: masked divide write; 0xB = code 7 = /1 (R2)
    wr_reg(12'h3E0, 32'hFFFF_FFFF);
    rd_reg(12'h3E0, 32'hB, "R3 divide mask");

    // R4/R5 with /1
    wr_reg(12'h380, 32'd5);
    rd_cur("R6 cur /1");
    idle(8);
    rd_cur("R5 cur after expiry");

    // R6: /2 with several reads
    wr_reg(12'h3E0, 32'h0);
    wr_reg(12'h380, 32'd3);
    rd_cur("R6 cur /2 a");
    rd_cur("R6 cur /2 b");
    idle(1);
    rd_cur("R6 cur /2 c");
    idle(6);
    rd_cur("R6 cur /2 idle");

    // R2: code 6 -> /128
    wr_reg(12'h3E0, 32'hA);
    rd_reg(12'h3E0, 32'hA, "R2 divide code 6");
    wr_reg(12'h380, 32'd2);
    idle(100);
    rd_cur("R2 cur /128");
    idle(170);

    // R2: code 3 -> /16, R7: writes to current count ignored
    wr_reg(12'h3E0, 32'h3);
    wr_reg(12'h380, 32'd4);
    idle(5);
    wr_reg(12'h390, 32'd1234);
    rd_cur("R7 cur after ignored write");
    idle(70);

    // R8: zero write stops the timer silently
    wr_reg(12'h3E0, 32'h7);
    wr_reg(12'h380, 32'd10);
    idle(3);
    wr_reg(12'h380, 32'd0);
    rd_cur("R8 cur after stop");
    idle(30);

    // R11: rewrite while running
    wr_reg(12'h380, 32'd100);
    idle(20);
    wr_reg(12'h380, 32'd4);
    rd_cur("R11 cur after rewrite");
    idle(10);

    // R9: read-only local-vector bits
    wr_reg(12'h320, 32'hFFFF_FFFF);
    rd_reg(12'h320, 32'hFFFF_AFFF, "R9 lvt ro bits");
    rd_reg(12'h380, 32'd4, "R11 initial readback");

    // R10: back-pressure on the response channel
    @(negedge clk);
    rsp_ready = 1'b0;
    rd_reg(12'h3E0, 32'h3, "R10 held response");
    chk(rsp_valid == 1'b1, "R10 rsp_valid held", rsp_valid, 1);
    chk(req_ready == 1'b0, "R10 req_ready low", req_ready, 0);
    idle(3);
    chk(rsp_valid == 1'b1, "R10 still valid", rsp_valid, 1);
    chk(rsp_data == 32'h3, "R10 data stable", rsp_data, 3);
    chk(req_ready == 1'b0, "R10 still stalled", req_ready, 0);
    rsp_ready = 1'b1;
    idle(2);
    chk(rsp_valid == 1'b0, "R10 drained", rsp_valid, 0);
    chk(exp_q.size() == 0, "R10 queue empty", exp_q.size(), 0);
    idle(5);
    finish_run();
  end
endmodule